// File: doc/BRIEF.md
# Raster Field Timing Generator

This block produces the horizontal and vertical raster timing of a standard-definition video encoder. It runs from a line-locked pixel clock. A pixel counter walks each line and a line counter walks each frame. A standard-select input picks the 50 Hz geometry (1728 clocks per line, 625-line frame) or the 60 Hz geometry (1716 clocks per line, 525-line frame). A two-bit field-length code picks one of three modes:

- true interlace, where each field is a whole number of lines plus a half line;
- a short non-interlaced field;
- a long non-interlaced field.

The block drives a line-start strobe, a field-start strobe and the field identity. It also drives a sync-pulse strobe at a programmable pixel of every line, and a gate that marks the selected closed-caption line in whichever fields are enabled.

The configuration inputs are meant to come straight from register flops. The block holds its own working copy of them and takes a new copy only when the raster returns to the top of the frame. A register write therefore never shortens or stretches a field. Sync-start values past the end of a line are clamped, so every line still carries exactly one pulse. The default sync start of 0x49 lines the pulse up with the reference sync edge of the composite output.

Top module: `raster_timing_gen`

## Requirements
- R1: While and right after reset the outputs show pixel 0, line 1 and field 1 (`field_id_o` = 0). The working configuration is then 50 Hz, interlaced (code 00), sync start 0x49 and caption off (code 00). It stays so until the first return to line 1.
- R2: `pixel_o` counts 0 to P-1 and then wraps to 0, with P = 1728 when `std_60hz_i` = 0 and P = 1716 when it is 1. `line_start_o` is high exactly when `pixel_o` is 0.
- R3: With field-length code 00 the line counter runs 1 to F over the whole frame (F = 625 at 50 Hz, 525 at 60 Hz), and H = (F+1)/2 is the boundary line. `field_id_o` is 1 (field 2) from pixel P/2 of line H to the end of line F, and 0 otherwise. `field_start_o` is high at line 1 pixel 0 and at line H pixel P/2.
- R4: With field-length code 01 each field is (F-1)/2 lines long (312 or 262), numbered from 1.
- R5: With field-length codes 10 and 11 each field is (F+1)/2 lines long (313 or 263). In both non-interlaced modes `field_id_o` stays 0, and `field_start_o` is high only at line 1 pixel 0.
- R6: `sync_start_o` is high for the one clock in which `pixel_o` equals the 11-bit sync-start value. A value above P-1 acts as P-1. Every line carries exactly one pulse.
- R7: The caption target line is T = N+4 at 60 Hz and T = N+1 at 50 Hz, where N is `cc_line_i`. `cc_gate_o` is high for every pixel of line T when `cc_enable_i[0]` is 1 and the field is field 1. It is also high for every pixel of line H+T when `cc_enable_i[1]` is 1 in interlaced mode. Code 00 is off, 01 is field 1 only, 10 is field 2 only and 11 is both fields.
- R8: The configuration inputs are captured only on the clock edge where the counters move from the last pixel of the last line to line 1 pixel 0. Changes at any other time have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| std_60hz_i | input | 1 | 1 = 60 Hz geometry, 0 = 50 Hz geometry |
| field_len_i | input | 2 | Field-length code (00 interlaced, 01 short, 1x long) |
| sync_start_i | input | 11 | Pixel at which the sync strobe fires |
| cc_enable_i | input | 2 | Caption field enable (bit 0 field 1, bit 1 field 2) |
| cc_line_i | input | 5 | Caption line selector N |
| pixel_o | output | PIX_W (11) | Current pixel within the line |
| line_o | output | LINE_W (10) | Current line, starting at 1 |
| field_id_o | output | 1 | 0 = field 1 (odd), 1 = field 2 (even) |
| field_start_o | output | 1 | First clock of a field |
| line_start_o | output | 1 | First clock of a line |
| sync_start_o | output | 1 | Sync-pulse start strobe |
| cc_gate_o | output | 1 | High throughout the active caption line |

## Verification
The hardest situation to reach is a configuration change landing in the middle of a frame. The change has to stay invisible until the frame wraps, and only then switch line length, frame length and caption placement all at once. The bench builds the design with a tiny geometry so that whole frames are cheap. It walks every combination of standard, field-length code and caption enable, with a rotating sync value that includes out-of-range ones. It writes each new configuration halfway through the running frame. Every output is then predicted arithmetically on every clock of the following frames.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int SYNC_W = 11;
    localparam int CCL_W  = 5;

    // reset value of the sync start: reference sync edge
    localparam logic [SYNC_W-1:0] SYNC_REF = 11'h049;

    typedef struct packed {
        logic              std60;
        logic [1:0]        flen;
        logic [SYNC_W-1:0] sync;
        logic [1:0]        cc_en;
        logic [CCL_W-1:0]  cc_line;
    } raster_cfg_t;

    localparam raster_cfg_t CFG_RESET = '{
        std60:   1'b0,
        flen:    2'b00,
        sync:    SYNC_REF,
        cc_en:   2'b00,
        cc_line: '0
    };

endpackage

// File: rtl/rt_geometry.sv
module rt_geometry
    import raster_pkg::*;
#(
    parameter int PIX_50   = 1728,
    parameter int PIX_60   = 1716,
    parameter int FRAME_50 = 625,
    parameter int FRAME_60 = 525,
    parameter int PIX_W    = 11,
    parameter int LINE_W   = 10
) (
    input  logic              std60,
    input  logic [1:0]        flen,
    input  logic [SYNC_W-1:0] sync_raw,
    output logic [PIX_W-1:0]  pix_last,
    output logic [PIX_W-1:0]  half_pix,
    output logic [PIX_W-1:0]  sync_pos,
    output logic [LINE_W-1:0] line_last,
    output logic [LINE_W-1:0] half_line,
    output logic              interlaced
);
    localparam int CW = (SYNC_W > PIX_W) ? SYNC_W : PIX_W;

    // per-standard constants, index 0 = 50 Hz, 1 = 60 Hz
    logic [1:0][PIX_W-1:0]  last_tbl, half_tbl;
    logic [1:0][LINE_W-1:0] frame_tbl, short_tbl, long_tbl;

    for (genvar s = 0; s < 2; s++) begin : g_std
        localparam int P = (s == 0) ? PIX_50 : PIX_60;
        localparam int F = (s == 0) ? FRAME_50 : FRAME_60;
        assign last_tbl[s]  = PIX_W'(P - 1);
        assign half_tbl[s]  = PIX_W'(P / 2);
        assign frame_tbl[s] = LINE_W'(F);
        assign short_tbl[s] = LINE_W'((F - 1) / 2);
        assign long_tbl[s]  = LINE_W'((F + 1) / 2);
    end

    logic [CW-1:0] sync_ext, last_ext;

    always_comb begin
        pix_last   = last_tbl[std60];
        half_pix   = half_tbl[std60];
        half_line  = long_tbl[std60];
        interlaced = (flen == 2'b00);
        unique case (flen)
            2'b00:   line_last = frame_tbl[std60];
            2'b01:   line_last = short_tbl[std60];
            default: line_last = long_tbl[std60];
        endcase
        sync_ext = CW'(sync_raw);
        last_ext = CW'(pix_last);
        sync_pos = (sync_ext > last_ext) ? pix_last : PIX_W'(sync_ext);
    end

endmodule

// File: rtl/rt_caption_gate.sv
module rt_caption_gate
    import raster_pkg::*;
#(
    parameter int LINE_W = 10
) (
    input  logic              std60,
    input  logic [1:0]        cc_en,
    input  logic [CCL_W-1:0]  cc_line,
    input  logic [LINE_W-1:0] line,
    input  logic [LINE_W-1:0] half_line,
    input  logic              field_id,
    input  logic              interlaced,
    output logic              gate
);
    localparam int AW = LINE_W + 2;

    logic [AW-1:0] tgt_f1, tgt_f2, line_ext;

    always_comb begin
        tgt_f1   = AW'(cc_line) + (std60 ? AW'(4) : AW'(1));
        tgt_f2   = AW'(half_line) + tgt_f1;
        line_ext = AW'(line);
        gate = (cc_en[0] && !field_id && (line_ext == tgt_f1)) ||
               (cc_en[1] && interlaced && (line_ext == tgt_f2));
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int PIX_50   = 1728,
    parameter int PIX_60   = 1716,
    parameter int FRAME_50 = 625,
    parameter int FRAME_60 = 525,
    parameter int PIX_W    = $clog2((PIX_50 > PIX_60) ? PIX_50 : PIX_60),
    parameter int LINE_W   = $clog2(((FRAME_50 > FRAME_60) ? FRAME_50 : FRAME_60) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              std_60hz_i,
    input  logic [1:0]        field_len_i,
    input  logic [10:0]       sync_start_i,
    input  logic [1:0]        cc_enable_i,
    input  logic [4:0]        cc_line_i,
    output logic [PIX_W-1:0]  pixel_o,
    output logic [LINE_W-1:0] line_o,
    output logic              field_id_o,
    output logic              field_start_o,
    output logic              line_start_o,
    output logic              sync_start_o,
    output logic              cc_gate_o
);
    typedef struct packed {
        logic [PIX_W-1:0]  pix;
        logic [LINE_W-1:0] line;
        raster_cfg_t       cfg;
    } state_t;

    state_t state_d, state_q;
    raster_cfg_t cfg_in;

    logic [PIX_W-1:0]  pix_last, half_pix, sync_pos;
    logic [LINE_W-1:0] line_last, half_line;
    logic              interlaced;
    logic              end_of_line, end_of_frame, in_field2;

    assign cfg_in = '{
        std60:   std_60hz_i,
        flen:    field_len_i,
        sync:    sync_start_i,
        cc_en:   cc_enable_i,
        cc_line: cc_line_i
    };

    rt_geometry #(
        .PIX_50  (PIX_50),
        .PIX_60  (PIX_60),
        .FRAME_50(FRAME_50),
        .FRAME_60(FRAME_60),
        .PIX_W   (PIX_W),
        .LINE_W  (LINE_W)
    ) u_geom (
        .std60     (state_q.cfg.std60),
        .flen      (state_q.cfg.flen),
        .sync_raw  (state_q.cfg.sync),
        .pix_last  (pix_last),
        .half_pix  (half_pix),
        .sync_pos  (sync_pos),
        .line_last (line_last),
        .half_line (half_line),
        .interlaced(interlaced)
    );

    always_comb begin
        end_of_line  = (state_q.pix == pix_last);
        end_of_frame = end_of_line && (state_q.line == line_last);
        in_field2    = interlaced &&
                       ((state_q.line > half_line) ||
                        ((state_q.line == half_line) && (state_q.pix >= half_pix)));

        state_d = state_q;
        if (end_of_line) begin
            state_d.pix = '0;
        end else begin
            state_d.pix = state_q.pix + PIX_W'(1);
        end
        if (end_of_frame) begin
            state_d.line = LINE_W'(1);
            state_d.cfg  = cfg_in;
        end else if (end_of_line) begin
            state_d.line = state_q.line + LINE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.pix  <= '0;
            state_q.line <= LINE_W'(1);
            state_q.cfg  <= CFG_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    rt_caption_gate #(
        .LINE_W(LINE_W)
    ) u_cc (
        .std60     (state_q.cfg.std60),
        .cc_en     (state_q.cfg.cc_en),
        .cc_line   (state_q.cfg.cc_line),
        .line      (state_q.line),
        .half_line (half_line),
        .field_id  (in_field2),
        .interlaced(interlaced),
        .gate      (cc_gate_o)
    );

    assign pixel_o       = state_q.pix;
    assign line_o        = state_q.line;
    assign field_id_o    = in_field2;
    assign line_start_o  = (state_q.pix == '0);
    assign sync_start_o  = (state_q.pix == sync_pos);
    assign field_start_o = ((state_q.pix == '0) && (state_q.line == LINE_W'(1))) ||
                           (interlaced && (state_q.line == half_line) &&
                            (state_q.pix == half_pix));

endmodule

// File: rtl/rt_timing_checker.sv
module rt_timing_checker
    import raster_pkg::*;
#(
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PIX_W-1:0]  pixel,
    input logic [PIX_W-1:0]  pix_last,
    input logic [LINE_W-1:0] line,
    input logic [LINE_W-1:0] line_last,
    input logic              interlaced,
    input logic              field_id,
    input logic              field_start,
    input logic              line_start,
    input logic              sync_pulse,
    input raster_cfg_t       cfg
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (line_start) begin
            seen_q <= sync_pulse;
        end else begin
            seen_q <= seen_q | sync_pulse;
        end
    end

    // R2: the pixel counter advances by one inside a line
    a_r2_pixel_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pixel != pix_last) |=> (pixel == $past(pixel) + PIX_W'(1)));

    // R2: the last pixel is followed by pixel 0
    a_r2_pixel_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pixel == pix_last) |=> (pixel == '0));

    // R3: field identity changes only on a field-start clock
    a_r3_field_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (field_id != $past(field_id)) |-> field_start);

    // R5: non-interlaced raster is always field 1
    a_r5_single_field: assert property (@(posedge clk) disable iff (!rst_n)
        !interlaced |-> !field_id);

    // R6: no second pulse inside a line
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pulse && !line_start) |-> !seen_q);

    // R6: a pulse has been seen by the end of every line
    a_r6_pulse_present: assert property (@(posedge clk) disable iff (!rst_n)
        (pixel == pix_last) |-> (seen_q || sync_pulse));

    // R8: working configuration holds except across the frame wrap
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !((pixel == pix_last) && (line == line_last)) |=> $stable(cfg));

endmodule

bind raster_timing_gen rt_timing_checker #(
    .PIX_W (PIX_W),
    .LINE_W(LINE_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pixel      (pixel_o),
    .pix_last   (pix_last),
    .line       (line_o),
    .line_last  (line_last),
    .interlaced (interlaced),
    .field_id   (field_id_o),
    .field_start(field_start_o),
    .line_start (line_start_o),
    .sync_pulse (sync_start_o),
    .cfg        (state_q.cfg)
);

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;

    localparam int P50 = 24;
    localparam int P60 = 20;
    localparam int F50 = 15;
    localparam int F60 = 13;
    localparam int PW  = $clog2(P50);
    localparam int LW  = $clog2(F50 + 1);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          std_60hz_i;
    logic [1:0]    field_len_i;
    logic [10:0]   sync_start_i;
    logic [1:0]    cc_enable_i;
    logic [4:0]    cc_line_i;
    logic [PW-1:0] pixel_o;
    logic [LW-1:0] line_o;
    logic          field_id_o, field_start_o, line_start_o, sync_start_o, cc_gate_o;

    raster_timing_gen #(
        .PIX_50(P50), .PIX_60(P60), .FRAME_50(F50), .FRAME_60(F60),
        .PIX_W(PW), .LINE_W(LW)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .std_60hz_i(std_60hz_i), .field_len_i(field_len_i),
        .sync_start_i(sync_start_i), .cc_enable_i(cc_enable_i),
        .cc_line_i(cc_line_i),
        .pixel_o(pixel_o), .line_o(line_o), .field_id_o(field_id_o),
        .field_start_o(field_start_o), .line_start_o(line_start_o),
        .sync_start_o(sync_start_o), .cc_gate_o(cc_gate_o)
    );

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;

    // working configuration the bench expects the design to use
    int a_std, a_flen, a_sync, a_cc, a_n;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_cfg(input int idx);
        int sync_set[5];
        sync_set = '{0, 7, 19, 40, 2047};
        std_60hz_i   = idx[0];
        field_len_i  = idx[2:1];
        cc_enable_i  = idx[4:3];
        sync_start_i = 11'(sync_set[idx % 5]);
        cc_line_i    = 5'(idx % 3);
    endtask

    // one full frame, checked on every clock; new inputs written mid-frame
    task automatic run_frame(input bit change, input int idx);
        int  p, f, l, h, sp, tgt, tot;
        bit  il, mid;
        p   = a_std ? P60 : P50;
        f   = a_std ? F60 : F50;
        il  = (a_flen == 0);
        l   = il ? f : ((a_flen == 1) ? (f - 1) / 2 : (f + 1) / 2);
        h   = (f + 1) / 2;
        sp  = (a_sync > p - 1) ? p - 1 : a_sync;
        tgt = a_n + (a_std ? 4 : 1);
        tot = p * l;
        mid = 0;
        for (int t = 0; t < tot; t++) begin
            int  px, ln;
            bit  fld, fst, ccx;
            px  = t % p;
            ln  = t / p + 1;
            fld = il && ((ln > h) || ((ln == h) && (px >= p / 2)));
            fst = (t == 0) || (il && (ln == h) && (px == p / 2));
            ccx = (a_cc[0] && !fld && (ln == tgt)) ||
                  (a_cc[1] && il && (ln == h + tgt));
            check("R2 pixel", int'(pixel_o), px);
            check("R2 line_start", int'(line_start_o), int'(px == 0));
            check(il ? "R3 line" : ((a_flen == 1) ? "R4 line" : "R5 line"),
                  int'(line_o), ln);
            check(il ? "R3 field_id" : "R5 field_id", int'(field_id_o), int'(fld));
            check(mid ? "R8 field_start" : "R3 field_start",
                  int'(field_start_o), int'(fst));
            check("R6 sync_start", int'(sync_start_o), int'(px == sp));
            check("R7 cc_gate", int'(cc_gate_o), int'(ccx));
            if (change && t == tot / 2) begin
                drive_cfg(idx);
                mid = 1;
            end
            @(negedge clk);
        end
        a_std  = int'(std_60hz_i);
        a_flen = int'(field_len_i);
        a_sync = int'(sync_start_i);
        a_cc   = int'(cc_enable_i);
        a_n    = int'(cc_line_i);
    endtask

    initial begin
        rst_n        = 1'b0;
        std_60hz_i   = 1'b1;
        field_len_i  = 2'b11;
        sync_start_i = 11'd3;
        cc_enable_i  = 2'b11;
        cc_line_i    = 5'd2;
        repeat (3) @(negedge clk);
        // R1: reset state visible while reset is held
        check("R1 pixel", int'(pixel_o), 0);
        check("R1 line", int'(line_o), 1);
        check("R1 field_id", int'(field_id_o), 0);
        check("R1 cc_gate", int'(cc_gate_o), 0);
        rst_n = 1'b1;
        // R1: defaults are 50 Hz, interlaced, sync 0x49 (clamped), caption off
        a_std = 0; a_flen = 0; a_sync = 'h49; a_cc = 0; a_n = 0;
        for (int i = 0; i < 64; i++) begin
            run_frame(1'b1, i);
        end
        run_frame(1'b0, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule